// File: doc/BRIEF.md
# Frame-Activity Power-Down Controller

This block decides whether a serial voice codec is powered up. It watches a dedicated pin that serves either as a static power-down control or as a running receive clock, and it watches the rising edges of the transmit and receive frame sync inputs. A frame sync edge wakes the block. Two things send it back to sleep: the pin held continuously high, or a period with no frame sync edges that lasts a set number of 8 kHz frame ticks.

It also gates the PCM serial data output. The output stays disabled while the block is asleep. After a wake-up it stays disabled until the second transmit frame sync edge, so the first frame, which holds no valid encoded sample, is never driven onto the line. All inputs are sampled on one system clock. The frame tick is a one-cycle strobe from a timebase outside the block.

Top module: `fsync_pwr_ctl`

## Requirements
- R1: After reset is released, `pwr_up` and `dx_permit` are both 0 until a wake condition occurs.
- R2: A rising edge on `fs_tx` or `fs_rx`, when no pin power-down request is active, sets `pwr_up` to 1 in the clock cycle after the edge is sampled.
- R3: When `pdn_pin` has been high with no edge for `PIN_WIN` consecutive clock cycles, a power-down request is active. `pwr_up` and `dx_permit` drop to 0, and frame sync edges do not wake the block while the request holds.
- R4: When `pdn_pin` toggles with gaps shorter than `PIN_WIN` cycles, it counts as a running clock and never forces power-down.
- R5: While awake, the `IDLE_TICKS`-th `frame_tick` strobe after the last frame sync edge (default 8, roughly 1 ms) clears `pwr_up` and `dx_permit`. Any frame sync edge restarts this count.
- R6: After each wake-up, `dx_permit` stays 0 until the second `fs_tx` rising edge counted from the wake-up (the waking edge counts if it is a transmit edge). It becomes 1 in the cycle after that edge.
- R7: `dx_permit` is never 1 while `pwr_up` is 0.
- R8: A frame sync held high for several cycles (long frame) counts as one edge only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdn_pin | input | 1 | Power-down level or receive clock, synchronised |
| fs_tx | input | 1 | Transmit frame sync, synchronised |
| fs_rx | input | 1 | Receive frame sync, synchronised |
| frame_tick | input | 1 | One-cycle strobe once per 8 kHz frame |
| pwr_up | output | 1 | 1 while the device is powered up |
| dx_permit | output | 1 | 1 when the serial data output may be driven |

## Verification
The assertions assume that every input is already synchronous to `clk`, that `frame_tick` is a single-cycle strobe, and that the frame syncs are low while reset is asserted, so the first edge after reset is a real edge. The stimulus changes inputs only on the falling clock edge. It keeps the syncs low through reset and issues ticks as one-cycle pulses. It toggles `pdn_pin` well inside or well outside the `PIN_WIN` window, never at its boundary.

// File: rtl/fsync_pwr_ctl.sv
module fsync_pwr_ctl #(
  parameter int PIN_WIN    = 16,
  parameter int IDLE_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_pin,
  input  logic fs_tx,
  input  logic fs_rx,
  input  logic frame_tick,
  output logic pwr_up,
  output logic dx_permit
);
  localparam int QW = $clog2(PIN_WIN + 1);
  localparam int IW = $clog2(IDLE_TICKS + 1);

  logic          pin_q, tx_q, rx_q;
  logic [QW-1:0] quiet;
  logic [IW-1:0] idle;
  logic [1:0]    tx_seen;
  logic          awake;

  always_ff @(posedge clk) begin
    pin_q <= pdn_pin;
    tx_q  <= fs_tx;
    rx_q  <= fs_rx;
  end

  wire pin_edge = pdn_pin ^ pin_q;
  wire pdn_req  = pin_q & (quiet == QW'(PIN_WIN));
  wire tx_rise  = fs_tx & ~tx_q;
  wire any_rise = tx_rise | (fs_rx & ~rx_q);
  wire expire   = awake & frame_tick & (idle == IW'(IDLE_TICKS - 1)) & ~any_rise;
  wire awake_nx = ~pdn_req & (any_rise | (awake & ~expire));

  always_ff @(posedge clk) begin
    if (!rst_n)
      quiet <= '0;
    else if (pin_edge)
      quiet <= '0;
    else if (quiet != QW'(PIN_WIN))
      quiet <= quiet + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !awake_nx || any_rise)
      idle <= '0;
    else if (frame_tick)
      idle <= idle + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awake   <= 1'b0;
      tx_seen <= 2'd0;
    end else begin
      awake <= awake_nx;
      if (!awake_nx)
        tx_seen <= 2'd0;
      else if (tx_rise && tx_seen != 2'd2)
        tx_seen <= tx_seen + 2'd1;
    end
  end

  assign pwr_up    = awake;
  assign dx_permit = awake & (tx_seen == 2'd2);
endmodule

// File: rtl/fsync_pwr_ctl_chk.sv
module fsync_pwr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic fs_tx,
  input logic fs_rx,
  input logic frame_tick,
  input logic pdn_req,
  input logic pwr_up,
  input logic dx_permit
);
  // R7
  permit_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_permit |-> pwr_up);

  // R2
  sync_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn_req && ($rose(fs_tx) || $rose(fs_rx))) |=> pwr_up);

  // R3
  pin_forces_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_req |=> (!pwr_up && !dx_permit));

  // R5
  sleep_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_up) |-> ($past(pdn_req) || $past(frame_tick)));

  // R6
  permit_follows_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_permit) |-> ($past(fs_tx) && $past(pwr_up)));
endmodule

bind fsync_pwr_ctl fsync_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
  .frame_tick(frame_tick), .pdn_req(pdn_req),
  .pwr_up(pwr_up), .dx_permit(dx_permit)
);

// File: tb/sim_fsync_pwr_ctl.sv
`timescale 1ns/1ps
module sim_fsync_pwr_ctl;
  localparam int PIN_WIN = 16;
  localparam int IDLE_TICKS = 8;

  logic clk = 0, rst_n = 0, pdn_pin = 0, fs_tx = 0, fs_rx = 0, frame_tick = 0;
  logic pwr_up, dx_permit;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  fsync_pwr_ctl #(.PIN_WIN(PIN_WIN), .IDLE_TICKS(IDLE_TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .pdn_pin(pdn_pin), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .frame_tick(frame_tick), .pwr_up(pwr_up), .dx_permit(dx_permit));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tx(); fs_tx = 1; step(1); fs_tx = 0; endtask
  task automatic pulse_rx(); fs_rx = 1; step(1); fs_rx = 0; endtask
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin frame_tick = 1; step(1); frame_tick = 0; step(1); end
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 pwr_up", pwr_up, 0);
    chk("R1 dx_permit", dx_permit, 0);
  endtask

  task automatic t_wake_tx();
    step(2);
    pulse_tx();
    chk("R2 tx wake", pwr_up, 1);
    chk("R6 first tx", dx_permit, 0);
    step(3);
    pulse_tx();
    chk("R6 second tx", dx_permit, 1);
  endtask

  task automatic t_idle();
    tick(IDLE_TICKS - 1);
    chk("R5 before limit", pwr_up, 1);
    tick(1);
    chk("R5 expired", pwr_up, 0);
    chk("R7 permit off", dx_permit, 0);
    pulse_rx();
    chk("R2 rx wake", pwr_up, 1);
    chk("R6 rx wake no permit", dx_permit, 0);
    tick(5);
    pulse_rx();
    tick(IDLE_TICKS - 1);
    chk("R5 restart", pwr_up, 1);
    tick(1);
    chk("R5 restart expired", pwr_up, 0);
  endtask

  task automatic t_long();
    pulse_rx();
    fs_tx = 1; step(6); fs_tx = 0; step(2);
    chk("R8 long tx one edge", dx_permit, 0);
    chk("R8 still up", pwr_up, 1);
    pulse_tx();
    chk("R6 permit after second", dx_permit, 1);
  endtask

  task automatic t_pin_high();
    pdn_pin = 1; step(PIN_WIN + 4);
    chk("R3 forced down", pwr_up, 0);
    chk("R3 permit down", dx_permit, 0);
    pulse_tx(); step(1);
    chk("R3 sync ignored", pwr_up, 0);
    pdn_pin = 0; step(2);
    pulse_tx();
    chk("R3 wake after release", pwr_up, 1);
  endtask

  task automatic t_pin_clocked();
    for (int i = 0; i < 20; i++) begin pdn_pin = ~pdn_pin; step(3); end
    chk("R4 clocked pin keeps up", pwr_up, 1);
    pulse_tx();
    for (int i = 0; i < 10; i++) begin pdn_pin = ~pdn_pin; step(PIN_WIN - 4); end
    chk("R4 slow clock keeps up", pwr_up, 1);
    chk("R6 permit with clocked pin", dx_permit, 1);
    pdn_pin = 0;
  endtask

  initial begin
    fork
      begin
        step(4); rst_n = 1;
        t_reset(); t_wake_tx(); t_idle(); t_long(); t_pin_high(); t_pin_clocked();
      end
      begin
        step(20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule